// File: doc/BRIEF.md
# Bus-master IDE DMA channel register block

This block holds the host-visible control and status registers of one bus-master IDE DMA channel. A byte-wide host port reads and writes a command register, a status register and a four-byte pointer to the descriptor table in memory. The command register drives a run signal and a transfer direction to the DMA engine. The status register collects engine activity, engine errors and drive interrupts. It also holds two capability flags, one per drive, that software may read and write freely.

Software programs the table pointer, sets the direction, and sets the run bit. When the drive interrupt arrives, software reads status and clears the interrupt and error bits by writing ones to them. A transfer counts as good when the three low status bits read exactly 100b, meaning not active, no error, and interrupt seen. The block computes that check in hardware. It also flags when both engine wait flags are set, which means a watchdog should keep waiting.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every readable byte (offsets 0 to 7) reads 0x00, and eng_start, eng_to_mem and tbl_ptr are 0.
- R2: Command register at offset 0. Bit 0 is the run bit and drives eng_start. Bit 3 is the direction bit and drives eng_to_mem, where 1 means the transfer writes to memory. Both follow the last write one cycle later. All other command bits read 0.
- R3: Status bit 0 (active) sets one cycle after a command write with bit 0 = 1 while the run bit was 0. It clears one cycle after a command write with bit 0 = 0, or after an eng_done pulse. When a set and a clear condition arrive together, the set wins.
- R4: Status bit 1 (error) sets on eng_err and status bit 2 (interrupt) sets on drv_irq. Each stays set until a status write (offset 2) carries a 1 in that bit. Writing 0 to the bit leaves it unchanged.
- R5: When an error or interrupt event arrives in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R6: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. They take the written value directly.
- R7: Status bits 4:3 show eng_flag[1:0], registered once. Bit 7 reads 0. Status writes have no effect on bits 0, 3, 4 and 7.
- R8: clean_done is 1 exactly when status bits 2:0 equal 100b.
- R9: keep_wait is 1 exactly when status bits 3 and 4 are both 1.
- R10: The table pointer is at offsets 4 to 7, least significant byte first. It drives tbl_ptr. Pointer bits 1:0 always read 0.
- R11: Pointer writes are ignored while status bit 0 is 1.
- R12: Offsets 1 and 3 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Byte offset within the channel |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| eng_start | output | 1 | Run request to the DMA engine |
| eng_to_mem | output | 1 | Direction: 1 = data goes into memory |
| tbl_ptr | output | PTR_W | Descriptor table base address |
| eng_done | input | 1 | Engine reached end of table (pulse) |
| eng_err | input | 1 | Engine error event (pulse) |
| drv_irq | input | 1 | Drive interrupt event |
| eng_flag | input | 2 | Engine wait flags shown in status bits 4:3 |
| clean_done | output | 1 | Status 2:0 equals 100b |
| keep_wait | output | 1 | Both wait flags set |

## Verification
Directed sequences drive the run, stop and end-of-table paths. These show whether the active bit follows writes or engine events. Error and interrupt events are aligned with write-one-to-clear writes in the same cycle, to tell event priority apart from plain clearing. Pointer writes are made both while the engine is active and while it is idle, which separates locking from byte-lane ordering. A long random phase mixes writes to every offset, including the unmapped ones, with random events. A behavioural model compares every output on every clock.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BYTE_W   = 8;
  // status bit positions (software decodes these)
  localparam int ST_ACT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_FLG0  = 3;
  localparam int ST_FLG1  = 4;
  localparam int ST_CAP0  = 5;
  localparam int ST_CAP1  = 6;
  // command bit positions
  localparam int CM_RUN   = 0;
  localparam int CM_DIR   = 3;
  // completion pattern on status 2:0
  localparam logic [2:0] GOOD_END = 3'b100;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic run_in,
  input  logic dir_in,
  output logic run_q,
  output logic dir_q
);
  logic run_d, dir_d;

  always_comb begin
    run_d = run_q;
    dir_d = dir_q;
    if (wr) begin
      run_d = run_in;
      dir_d = dir_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      run_q <= run_d;
      dir_q <= dir_d;
    end
  end

  // R2
  run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (run_q == $past(run_in)) && (dir_q == $past(dir_in)));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clr_err,
  input  logic              clr_irq,
  input  logic [1:0]        cap_in,
  input  logic              run_set,
  input  logic              run_clr,
  input  logic              ev_err,
  input  logic              ev_irq,
  input  logic [1:0]        flag_in,
  output logic [BYTE_W-1:0] status
);
  logic act_q, err_q, irq_q;
  logic act_d, err_d, irq_d;
  logic [1:0] flg_q, cap_q, cap_d;

  always_comb begin
    act_d = act_q;
    if (run_set)      act_d = 1'b1;
    else if (run_clr) act_d = 1'b0;
    err_d = err_q;
    if (ev_err)                err_d = 1'b1;
    else if (wr && clr_err)    err_d = 1'b0;
    irq_d = irq_q;
    if (ev_irq)                irq_d = 1'b1;
    else if (wr && clr_irq)    irq_d = 1'b0;
    cap_d = wr ? cap_in : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      flg_q <= 2'b00;
      cap_q <= 2'b00;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
      irq_q <= irq_d;
      flg_q <= flag_in;
      cap_q <= cap_d;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_ACT]  = act_q;
    status[ST_ERR]  = err_q;
    status[ST_IRQ]  = irq_q;
    status[ST_FLG0] = flg_q[0];
    status[ST_FLG1] = flg_q[1];
    status[ST_CAP0] = cap_q[0];
    status[ST_CAP1] = cap_q[1];
  end

  // R5
  err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> status[ST_ERR]);
  // R5
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq |=> status[ST_IRQ]);
  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_ERR] && !(wr && clr_err)) |=> status[ST_ERR]);
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg
  import bmdma_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int PW    = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] byte_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lock,
  output logic [PW-1:0]     ptr
);
  logic [PW-1:0] ptr_d;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_in;
    if (i == 0) begin : g_low
      assign lane_in = {wdata[BYTE_W-1:2], 2'b00};
    end else begin : g_hi
      assign lane_in = wdata;
    end
    always_comb begin
      ptr_d[i*BYTE_W +: BYTE_W] = ptr[i*BYTE_W +: BYTE_W];
      if (byte_we[i] && !lock) ptr_d[i*BYTE_W +: BYTE_W] = lane_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  // R11
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(ptr));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int PTR_W    = 32,
  parameter int CMD_OFS  = 0,
  parameter int STAT_OFS = 2,
  parameter int PTR_OFS  = 4,
  localparam int PTR_BYTES = PTR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              eng_start,
  output logic              eng_to_mem,
  output logic [PTR_W-1:0]  tbl_ptr,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              drv_irq,
  input  logic [1:0]        eng_flag,
  output logic              clean_done,
  output logic              keep_wait
);
  logic cmd_we, stat_we, run_set, run_clr;
  logic [PTR_BYTES-1:0] ptr_we;
  logic [BYTE_W-1:0] status;

  assign cmd_we  = host_wr && (host_addr == ADDR_W'(CMD_OFS));
  assign stat_we = host_wr && (host_addr == ADDR_W'(STAT_OFS));
  assign run_set = cmd_we && host_wdata[CM_RUN] && !eng_start;
  assign run_clr = (cmd_we && !host_wdata[CM_RUN]) || eng_done;

  for (genvar i = 0; i < PTR_BYTES; i++) begin : g_we
    assign ptr_we[i] = host_wr && (host_addr == ADDR_W'(PTR_OFS + i));
  end

  bmdma_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_we),
    .run_in(host_wdata[CM_RUN]), .dir_in(host_wdata[CM_DIR]),
    .run_q(eng_start), .dir_q(eng_to_mem)
  );

  bmdma_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wr(stat_we),
    .clr_err(host_wdata[ST_ERR]), .clr_irq(host_wdata[ST_IRQ]),
    .cap_in({host_wdata[ST_CAP1], host_wdata[ST_CAP0]}),
    .run_set(run_set), .run_clr(run_clr),
    .ev_err(eng_err), .ev_irq(drv_irq), .flag_in(eng_flag),
    .status(status)
  );

  bmdma_ptr_reg #(.NBYTES(PTR_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .byte_we(ptr_we), .wdata(host_wdata),
    .lock(status[ST_ACT]), .ptr(tbl_ptr)
  );

  assign clean_done = (status[2:0] == GOOD_END);
  assign keep_wait  = status[ST_FLG0] && status[ST_FLG1];

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(CMD_OFS)) begin
      host_rdata[CM_RUN] = eng_start;
      host_rdata[CM_DIR] = eng_to_mem;
    end
    if (host_addr == ADDR_W'(STAT_OFS)) host_rdata = status;
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (host_addr == ADDR_W'(PTR_OFS + i)) host_rdata = tbl_ptr[i*BYTE_W +: BYTE_W];
    end
  end

  // R3
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_set |=> status[ST_ACT]);
  // R3
  act_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !run_set) |=> !status[ST_ACT]);
endmodule

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic eng_start, eng_to_mem, clean_done, keep_wait;
  logic [31:0] tbl_ptr;
  logic eng_done = 1'b0, eng_err = 1'b0, drv_irq = 1'b0;
  logic [1:0] eng_flag = 2'b00;

  int checks = 0, errors = 0, cycles = 0;

  bmdma_regs dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_start(eng_start),
    .eng_to_mem(eng_to_mem), .tbl_ptr(tbl_ptr), .eng_done(eng_done),
    .eng_err(eng_err), .drv_irq(drv_irq), .eng_flag(eng_flag),
    .clean_done(clean_done), .keep_wait(keep_wait)
  );

  always #2 clk = ~clk;

  // behavioural reference
  bit m_run, m_dir, m_act, m_err, m_irq;
  bit [1:0] m_cap, m_flg;
  bit [7:0] m_ptr [4];

  function automatic bit [7:0] m_status();
    return {1'b0, m_cap, m_flg, m_irq, m_err, m_act};
  endfunction

  function automatic bit [7:0] m_read(int a);
    if (a == 0) return {4'b0, m_dir, 2'b0, m_run};
    if (a == 2) return m_status();
    if (a >= 4) return m_ptr[a-4];
    return 8'h00;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int a;
    bit was_act;
    a = int'(host_addr);
    was_act = m_act;
    if (!rst_n) begin
      m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0;
      m_cap = 0; m_flg = 0;
      foreach (m_ptr[k]) m_ptr[k] = 0;
    end else begin
      if (host_wr && a == 0) begin
        if (host_wdata[0] && !m_run) m_act = 1;
        else if (!host_wdata[0]) m_act = 0;
        else if (eng_done) m_act = 0;
        m_run = host_wdata[0];
        m_dir = host_wdata[3];
      end else if (eng_done) m_act = 0;
      if (host_wr && a == 2) begin
        if (host_wdata[1]) m_err = 0;
        if (host_wdata[2]) m_irq = 0;
        m_cap = host_wdata[6:5];
      end
      if (eng_err) m_err = 1;
      if (drv_irq) m_irq = 1;
      m_flg = eng_flag;
      if (host_wr && a >= 4 && !was_act)
        m_ptr[a-4] = (a == 4) ? (host_wdata & 8'hFC) : host_wdata;
    end
    #1;
    if (rst_n) begin
      chk("R2 eng_start", eng_start, m_run);
      chk("R2 eng_to_mem", eng_to_mem, m_dir);
      chk("R10 tbl_ptr", tbl_ptr, {m_ptr[3], m_ptr[2], m_ptr[1], m_ptr[0]});
      chk("R8 clean_done", clean_done, m_status() % 8 == 4);
      chk("R9 keep_wait", keep_wait, m_flg == 2'b11);
      case (a)
        0: chk("R2 rdata", host_rdata, m_read(a));
        2: chk("R4 rdata", host_rdata, m_read(a));
        1, 3: chk("R12 rdata", host_rdata, m_read(a));
        default: chk("R10 rdata", host_rdata, m_read(a));
      endcase
    end
  end

  task automatic wr(int a, bit [7:0] d);
    @(negedge clk);
    host_addr = 3'(a); host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(string tag, int a, bit [7:0] exp);
    host_addr = 3'(a);
    #0.5;
    chk(tag, host_rdata, exp);
  endtask

  task automatic ev(bit d, bit e, bit i);
    @(negedge clk);
    eng_done = d; eng_err = e; drv_irq = i;
    @(negedge clk);
    eng_done = 0; eng_err = 0; drv_irq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1 reset read", a, 8'h00);
    chk("R1 eng_start", eng_start, 0);
    chk("R1 tbl_ptr", tbl_ptr, 0);
    rst_n = 1;
    @(negedge clk);
    // R2/R3 start with direction
    wr(0, 8'hFF);
    rd("R2 cmd read", 0, 8'h09);
    chk("R2 run", eng_start, 1);
    chk("R2 dir", eng_to_mem, 1);
    rd("R3 active set", 2, 8'h01);
    // R11 locked pointer
    wr(4, 8'h55);
    rd("R11 ptr locked", 4, 8'h00);
    // R3 end of table
    ev(1, 0, 0);
    rd("R3 done clears", 2, 8'h00);
    rd("R2 cmd kept", 0, 8'h09);
    // R10 pointer bytes
    wr(4, 8'h13); wr(5, 8'h22); wr(6, 8'h33); wr(7, 8'h44);
    chk("R10 ptr value", tbl_ptr, 32'h4433_2210);
    // R3 stop via command
    wr(0, 8'h00); wr(0, 8'h01);
    rd("R3 restart", 2, 8'h01);
    wr(0, 8'h00);
    rd("R3 stop by write", 2, 8'h00);
    // R4/R8
    ev(0, 0, 1);
    rd("R4 irq set", 2, 8'h04);
    chk("R8 good end", clean_done, 1);
    ev(0, 1, 0);
    rd("R4 err set", 2, 8'h06);
    chk("R8 bad end", clean_done, 0);
    wr(2, 8'h02);
    rd("R4 err cleared", 2, 8'h04);
    wr(2, 8'h00);
    rd("R4 write zero keeps", 2, 8'h04);
    wr(2, 8'h04);
    rd("R4 irq cleared", 2, 8'h00);
    // R5 event beats clear
    @(negedge clk);
    host_addr = 2; host_wdata = 8'h06; host_wr = 1; drv_irq = 1; eng_err = 1;
    @(negedge clk);
    host_wr = 0; drv_irq = 0; eng_err = 0;
    rd("R5 event wins", 2, 8'h06);
    // R6/R7
    wr(2, 8'hFF);
    rd("R6 caps set, R7 others untouched", 2, 8'h60);
    wr(2, 8'h20);
    rd("R6 cap1 cleared", 2, 8'h20);
    // R9
    @(negedge clk); eng_flag = 2'b11;
    @(negedge clk);
    rd("R7 flags shown", 2, 8'h38);
    chk("R9 keep_wait on", keep_wait, 1);
    eng_flag = 2'b01;
    @(negedge clk);
    chk("R9 keep_wait off", keep_wait, 0);
    eng_flag = 2'b00;
    // R12
    wr(1, 8'hFF); wr(3, 8'hFF);
    rd("R12 off1", 1, 8'h00);
    rd("R12 off3", 3, 8'h00);
    rd("R12 cmd untouched", 0, 8'h00);
    // random phase, model compares each clock
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      host_addr = 3'($urandom_range(0, 7));
      host_wr = ($urandom_range(0, 2) == 0);
      host_wdata = 8'($urandom);
      eng_done = ($urandom_range(0, 5) == 0);
      eng_err = ($urandom_range(0, 7) == 0);
      drv_irq = ($urandom_range(0, 6) == 0);
      eng_flag = 2'($urandom);
    end
    @(negedge clk);
    host_wr = 0; eng_done = 0; eng_err = 0; drv_irq = 0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule